// File: doc/BRIEF.md
# DRAM Refresh Requester

This block is a bus requester whose only job is to keep DRAM rows refreshed. A free-running interval timer marks the moment each row becomes due. The block then pulls its active-low request line to the bus arbiter. When the arbiter's active-low acknowledge comes back, the block owns the bus for a fixed number of clocks. During those clocks it drives its row counter onto the address bus and a fixed byte-enable pattern. It then pulses a refresh-done strobe and steps to the next row.

The arbiter may leave the request waiting while other masters hold the bus. If that happens, further intervals can expire. Each expiry adds one to a backlog of owed refreshes, and the backlog stops counting at a fixed ceiling. Each refresh that completes removes one owed refresh. If any remain owed after a completion, the request is raised again on the very next clock instead of waiting for the next interval. The DRAM timing and the arbiter are outside this block.

Top module: `rfq_refresh_requester`

## Requirements
- R1: Reset state: `ref_req_n` high, `ref_done` low, `ref_addr` all zeros, `ref_be_n` all ones, and the first refresh after reset uses row 0.
- R2: An owed refresh is added every `INTERVAL` clocks (120 by default), at clock edge k*`INTERVAL` counted from reset release. If the block is idle with nothing owed, `ref_req_n` goes low one clock after that edge.
- R3: While `ref_req_n` is low, an edge that samples `ref_ack_n` low starts the owned phase. The owned phase lasts `CYC_LEN` clocks. During it, `ref_addr[ROW_W+1:2]` carries the row (`ROW_W` = 14 by default) and `ref_addr[1:0]` is 0.
- R4: During the owned phase `ref_be_n` equals `BE_N_PAT`. At all other times `ref_be_n` is all ones and `ref_addr` is all zeros.
- R5: `ref_done` is high for exactly one clock, the clock right after the last owned clock, and `ref_req_n` is high in that clock.
- R6: The row advances by one after every completed refresh and wraps from all ones to zero.
- R7: Each interval expiry adds one owed refresh, and the count never exceeds `MAX_PEND` (4 by default). After long starvation, exactly `MAX_PEND` refreshes run back to back.
- R8: Each completed refresh removes one owed refresh. When an expiry and a completion fall on the same edge, the owed count is unchanged, including at the ceiling.
- R9: If refreshes remain owed after a completion, `ref_req_n` is low again in the clock after the `ref_done` clock, with no idle clock between.
- R10: `ref_ack_n` has no effect while `ref_req_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req_n | output | 1 | Active-low bus request to the arbiter |
| ref_ack_n | input | 1 | Active-low bus grant from the arbiter |
| ref_addr | output | ROW_W+2 | Refresh address, row on bits ROW_W+1:2, zero when not owning |
| ref_be_n | output | BE_W | Byte enables, `BE_N_PAT` when owning, all ones otherwise |
| ref_done | output | 1 | One-clock strobe after each completed refresh |

## Verification
The hard case is a clock edge where an interval expiry and a refresh completion both change the owed count. The bench sweeps the arbiter's grant delay from zero to well past one interval. At one delay in that sweep, the completion clock lines up with an expiry, both while idle and while a backlog is waiting. A behavioural reference model judges every clock of this. It works out the owed count from the sum of the increment and the decrement and clamps only after adding them. The bench also confirms that such a coincidence really happened, and a sustained starvation phase repeats it at the ceiling.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

   typedef enum logic [1:0] {
      RQ_IDLE = 2'd0,
      RQ_WAIT = 2'd1,
      RQ_OWN  = 2'd2,
      RQ_DONE = 2'd3
   } rfq_state_e;

endpackage

// File: rtl/rfq_interval_timer.sv
module rfq_interval_timer #(
   parameter int INTERVAL = 120
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int TW = $clog2(INTERVAL + 1);
   localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

   logic [TW-1:0] cnt_q;

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("rfq_interval_timer: INTERVAL must be at least 2");
      end
   endgenerate

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R2: expiries are never adjacent
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/rfq_backlog.sv
module rfq_backlog #(
   parameter int MAX_PEND = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            inc_i,
   input  logic                            dec_i,
   output logic [$clog2(MAX_PEND+1)-1:0]   pend_o,
   output logic                            next_nz_o
);
   localparam int PW = $clog2(MAX_PEND + 1);
   localparam logic [PW:0] CAP = (PW+1)'(MAX_PEND);

   logic [PW-1:0] pend_q;
   logic [PW:0]   sum;
   logic [PW-1:0] pend_d;
   logic          dec_ok;

   generate
      if (MAX_PEND < 1) begin : g_bad_cap
         $error("rfq_backlog: MAX_PEND must be at least 1");
      end
   endgenerate

   assign dec_ok = dec_i && (pend_q != '0);

   always_comb begin
      sum = {1'b0, pend_q} + {{PW{1'b0}}, inc_i} - {{PW{1'b0}}, dec_ok};
      if (sum > CAP) pend_d = CAP[PW-1:0];
      else           pend_d = sum[PW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend_o    = pend_q;
   assign next_nz_o = (pend_d != '0);

   assert_pend_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= CAP[PW-1:0]);

   assert_pend_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !dec_i && ({1'b0, pend_q} < CAP)) |=> pend_q == $past(pend_q) + 1'b1);

   assert_pend_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !inc_i) |=> pend_q == $past(pend_q) - 1'b1);

   assert_pend_net_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && inc_i) |=> $stable(pend_q));

endmodule

// File: rtl/rfq_row_counter.sv
module rfq_row_counter #(
   parameter int ROW_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   output logic [ROW_W-1:0] row_o
);
   logic [ROW_W-1:0] row_q;

   generate
      if (ROW_W < 1) begin : g_bad_row
         $error("rfq_row_counter: ROW_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     row_q <= '0;
      else if (adv_i) row_q <= row_q + 1'b1;
   end

   assign row_o = row_q;

   assert_row_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> row_o == ROW_W'($past(row_o) + 1'b1));

   assert_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(row_o));

endmodule

// File: rtl/rfq_sequencer.sv
module rfq_sequencer
   import rfq_pkg::*;
#(
   parameter int CYC_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_nz_i,
   input  logic next_nz_i,
   input  logic ack_n_i,
   output logic own_o,
   output logic done_o,
   output logic req_n_o
);
   localparam int CW = $clog2(CYC_LEN + 1);

   rfq_state_e state_q, state_d;
   logic       last_own;

   generate
      if (CYC_LEN < 1) begin : g_bad_len
         $error("rfq_sequencer: CYC_LEN must be at least 1");
      end
      if (CYC_LEN == 1) begin : g_single
         assign last_own = 1'b1;
      end else begin : g_multi
         localparam logic [CW-1:0] LAST = CW'(CYC_LEN - 1);
         logic [CW-1:0] bcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  bcnt_q <= '0;
            else if (state_q != RQ_OWN)  bcnt_q <= '0;
            else if (!last_own)          bcnt_q <= bcnt_q + 1'b1;
         end
         assign last_own = (bcnt_q == LAST);
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         RQ_IDLE: if (pend_nz_i) state_d = RQ_WAIT;
         RQ_WAIT: if (!ack_n_i)  state_d = RQ_OWN;
         RQ_OWN:  if (last_own)  state_d = RQ_DONE;
         RQ_DONE: state_d = next_nz_i ? RQ_WAIT : RQ_IDLE;
         default: state_d = RQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RQ_IDLE;
      else        state_q <= state_d;
   end

   assign own_o   = (state_q == RQ_OWN);
   assign done_o  = (state_q == RQ_DONE);
   assign req_n_o = !((state_q == RQ_WAIT) || (state_q == RQ_OWN));

   // R10: a grant seen while not requesting leaves the sequencer idle
   assert_ack_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RQ_IDLE) |=> (state_q != RQ_OWN));

endmodule

// File: rtl/rfq_refresh_requester.sv
module rfq_refresh_requester #(
   parameter int              INTERVAL = 120,
   parameter int              ROW_W    = 14,
   parameter int              MAX_PEND = 4,
   parameter int              CYC_LEN  = 4,
   parameter int              BE_W     = 4,
   parameter logic [BE_W-1:0] BE_N_PAT = 4'b0001
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ref_req_n,
   input  logic              ref_ack_n,
   output logic [ROW_W+1:0]  ref_addr,
   output logic [BE_W-1:0]   ref_be_n,
   output logic              ref_done
);
   localparam int PW = $clog2(MAX_PEND + 1);

   logic             tick;
   logic [PW-1:0]    pend;
   logic             pend_nz;
   logic             next_nz;
   logic             own;
   logic [ROW_W-1:0] row;

   rfq_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   rfq_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (tick),
      .dec_i     (ref_done),
      .pend_o    (pend),
      .next_nz_o (next_nz)
   );

   assign pend_nz = (pend != '0);

   rfq_sequencer #(.CYC_LEN(CYC_LEN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_nz_i (pend_nz),
      .next_nz_i (next_nz),
      .ack_n_i   (ref_ack_n),
      .own_o     (own),
      .done_o    (ref_done),
      .req_n_o   (ref_req_n)
   );

   rfq_row_counter #(.ROW_W(ROW_W)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (ref_done),
      .row_o (row)
   );

   assign ref_addr = own ? {row, 2'b00} : '0;
   assign ref_be_n = own ? BE_N_PAT : '1;

   assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req_n |-> (ref_addr == '0 && ref_be_n == '1));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_done |=> !ref_done);

   assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ref_done |-> ref_req_n);

   assert_rerequest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_done && (pend > 1)) |=> !ref_req_n);

   assert_req_owed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_req_n && !own) |-> pend_nz);

endmodule

// File: tb/test_rfq_refresh_requester.sv
module test_rfq_refresh_requester;

   localparam int INT = 24;
   localparam int ROWB = 8;
   localparam int MAXP = 4;
   localparam int CYC = 3;
   localparam logic [3:0] PAT = 4'b0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_req_n;
   logic ref_ack_n = 1'b1;
   logic [ROWB+1:0] ref_addr;
   logic [3:0] ref_be_n;
   logic ref_done;

   always #5 clk = ~clk;

   rfq_refresh_requester #(
      .INTERVAL(INT), .ROW_W(ROWB), .MAX_PEND(MAXP), .CYC_LEN(CYC),
      .BE_W(4), .BE_N_PAT(PAT)
   ) i_rfq_refresh_requester (
      .clk(clk), .rst_n(rst_n), .ref_req_n(ref_req_n), .ref_ack_n(ref_ack_n),
      .ref_addr(ref_addr), .ref_be_n(ref_be_n), .ref_done(ref_done)
   );

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference model: phase 0 idle, 1 asking, 2 owning, 3 finishing
   int cyc = 0;
   int m_t = 0, m_p = 0, m_row = 0, m_ph = 0, m_b = 0;
   int tk, dn, np, nph, nb, nrow;
   int coinc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_t = 0; m_p = 0; m_row = 0; m_ph = 0; m_b = 0; cyc = 0;
      end else begin
         cyc++;
         tk = (m_t == INT - 1) ? 1 : 0;
         dn = (m_ph == 3) ? 1 : 0;
         np = m_p + tk - dn;
         if (np > MAXP) np = MAXP;
         nph = m_ph; nb = m_b; nrow = m_row;
         case (m_ph)
            0: if (m_p > 0) nph = 1;
            1: if (ref_ack_n == 1'b0) begin nph = 2; nb = 0; end
            2: if (m_b == CYC - 1) nph = 3; else nb = m_b + 1;
            default: begin
               nph = (np > 0) ? 1 : 0;
               nrow = (m_row + 1) % (1 << ROWB);
            end
         endcase
         if (tk == 1 && dn == 1) coinc++;
         m_t = (tk == 1) ? 0 : m_t + 1;
         m_p = np; m_ph = nph; m_b = nb; m_row = nrow;
      end
   end

   // arbiter behaviour
   bit ack_en = 0;
   bit ack_force = 0;
   int ack_dly = 0;
   int ack_ctr = 0;

   int burst_dones = 0;
   int own_row = -1;
   int prev_row = -1;
   int wraps = 0;

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(ref_req_n == ((m_ph == 1 || m_ph == 2) ? 1'b0 : 1'b1), "R9 req", int'(ref_req_n),
             (m_ph == 1 || m_ph == 2) ? 0 : 1);
         chk(int'(ref_addr) == ((m_ph == 2) ? m_row * 4 : 0), "R3 addr", int'(ref_addr),
             (m_ph == 2) ? m_row * 4 : 0);
         chk(ref_be_n == ((m_ph == 2) ? PAT : 4'hF), "R4 be_n", int'(ref_be_n),
             (m_ph == 2) ? int'(PAT) : 15);
         chk(ref_done == ((m_ph == 3) ? 1'b1 : 1'b0), "R5 done", int'(ref_done),
             (m_ph == 3) ? 1 : 0);
         if (cyc == INT) chk(ref_req_n == 1'b1, "R2 before expiry", int'(ref_req_n), 1);
         if (cyc == INT + 1) chk(ref_req_n == 1'b0, "R2 after expiry", int'(ref_req_n), 0);
         if (cyc >= 8 * INT + 2 && cyc <= 8 * INT + 22 && ref_done) burst_dones++;
         if (cyc >= 9 * INT + 9 && cyc <= 9 * INT + 22) begin
            chk(ref_req_n == 1'b1 && ref_done == 1'b0 && ref_addr == '0,
                "R10 grant while idle", int'(ref_req_n) + 2 * int'(ref_done), 1);
         end
         if (ref_be_n == PAT) own_row = int'(ref_addr) / 4;
         if (ref_done) begin
            if (prev_row >= 0)
               chk(own_row == (prev_row + 1) % (1 << ROWB), "R6 row step", own_row,
                   (prev_row + 1) % (1 << ROWB));
            else
               chk(own_row == 0, "R1 first row", own_row, 0);
            if (prev_row == (1 << ROWB) - 1 && own_row == 0) wraps++;
            prev_row = own_row;
         end
      end
      if (ref_req_n == 1'b0 && ack_en) begin
         if (ack_ctr >= ack_dly) ref_ack_n = 1'b0;
         else ack_ctr++;
      end else begin
         ref_ack_n = ack_force ? 1'b0 : 1'b1;
         if (ref_req_n == 1'b1) ack_ctr = 0;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ref_req_n == 1'b1, "R1 req_n", int'(ref_req_n), 1);
      chk(ref_done == 1'b0, "R1 done", int'(ref_done), 0);
      chk(ref_addr == '0, "R1 addr", int'(ref_addr), 0);
      chk(ref_be_n == 4'hF, "R1 be_n", int'(ref_be_n), 15);
      rst_n = 1'b1;
      // starve the requester so the backlog reaches its ceiling
      wait (cyc == 8 * INT + 1);
      ack_dly = 0; ack_en = 1;
      wait (cyc == 8 * INT + 23);
      chk(burst_dones == MAXP, "R7 back-to-back after starvation", burst_dones, MAXP);
      wait (cyc == 9 * INT + 8);
      ack_force = 1;
      wait (cyc == 9 * INT + 23);
      ack_force = 0;
      // sweep the grant delay across and beyond one interval
      for (int d = 0; d <= 40; d++) begin
         ack_dly = d;
         wait (cyc == 10 * INT + d * 3 * INT);
      end
      ack_dly = 2;
      wait (cyc == 7000);
      chk(wraps >= 1, "R6 wrap to zero", wraps, 1);
      chk(coinc > 0, "R8 expiry with completion", coinc, 1);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(10 * 20000);
      if (!finished) begin
         finished = 1;
         tests++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 7000);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule